// File: doc/BRIEF.md
# System Clock Switch with Slewed Post-Divider

The block picks the system clock from up to eight source clock inputs and sets the post-divider that follows it. Software writes a requested source index together with a go bit into the oscillator control register. The hardware then checks that the requested source reports ready. If it does not, the request is refused: the go bit clears and the current source stays as it was. If it does, the hardware waits for a cycle in which both the outgoing and the incoming source are low, moves the selection, and clears the go bit. Software learns the outcome by reading the current-source field.

The second register holds the target post-divider field and the slew controls. A new target can jump straight to its value. It can also step there one division at a time, paced by a programmable step period, with separate enables for raising and lowering the division. A busy flag stays up until the effective division matches the target. Source clocks and ready flags arrive as plain signals sampled on the register clock.

Top module: `sclk_switch`

## Requirements
- R1: After reset the current source, the requested source, the go bit, both slew enables, the step field and the post-divider field are all zero, so the division is 1 and `div_act_o` reads 0.
- R2: Oscillator register (`addr_i`=0): bits [10:8] hold the requested source (read/write), bits [14:12] hold the current source (read-only), and bit 0 is the go bit. Writing 1 to the go bit starts a switch.
- R3: An accepted switch loads the current source with the requested one and clears the go bit. From then on `mux_clk_o` follows the new source.
- R4: The current source changes only on an edge at which both the old and the new source clock were sampled low.
- R5: If the requested source's ready input is low at any cycle while a switch is pending, the go bit clears and the current source is unchanged.
- R6: Writes to the oscillator register are ignored while a switch is pending.
- R7: Slew register (`addr_i`=1): bit 0 is busy (read-only), bit 1 enables slewing when the division increases, bit 2 enables slewing when it decreases, bits [10:8] hold the step field, and bits [23:20] hold the target division field. `div_act_o` shows the effective division minus 1.
- R8: The busy bit reads 1 from the write that sets a new target until the effective division equals the target.
- R9: When slewing is not enabled for the direction of a change, the effective division takes the target on the edge after the write.
- R10: With slewing enabled, the effective division moves by one every step+1 cycles. A change of D steps therefore keeps busy high for D*(step+1) cycles.
- R11: An increasing division field is governed by bit 1 alone, and a decreasing one by bit 2 alone.
- R12: Writes to the slew register are ignored while busy is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register and control clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | 0 selects the oscillator register, 1 selects the slew register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| src_clk_i | input | 8 | Source clock levels |
| src_rdy_i | input | 8 | Source ready flags |
| mux_clk_o | output | 1 | Selected source clock |
| div_act_o | output | 4 | Effective post-division minus 1 |

## Verification
Two situations are hard to reach from the ports. The first is a switch that stays pending long enough to be hit by a second write or by a ready drop. The bench creates it by holding the requested source's clock high, which means the both-low condition never occurs. It then releases the clock, or drops the ready flag, to end the wait. The second is a switch-over cycle that has to be proven safe. The bench records the source levels at the negative edge before the go bit reads clear and checks that both the old and the new source were low there. Slew timing is covered by a table that mixes directions, enable combinations and step periods, and compares the busy duration with D*(step+1).

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned SRC_MAX    = 8;
  localparam int unsigned SEL_FLD_W  = 3;
  localparam int unsigned DIV_FLD_W  = 4;
  localparam int unsigned STEP_FLD_W = 3;
  // oscillator register
  localparam int unsigned GO_BIT     = 0;
  localparam int unsigned REQ_LSB    = 8;
  localparam int unsigned CUR_LSB    = 12;
  // slew register
  localparam int unsigned BUSY_BIT   = 0;
  localparam int unsigned DN_BIT     = 1;
  localparam int unsigned UP_BIT     = 2;
  localparam int unsigned STEP_LSB   = 8;
  localparam int unsigned DIV_LSB    = 20;
  typedef enum logic {ADDR_OSC = 1'b0, ADDR_SLEW = 1'b1} reg_addr_e;
endpackage

// File: rtl/sclk_src_switch.sv
module sclk_src_switch #(
  parameter int unsigned NUM_SRC = 8,
  parameter int unsigned SEL_W   = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic [SEL_W-1:0]   wr_sel_i,
  input  logic               wr_go_i,
  input  logic [NUM_SRC-1:0] src_clk_i,
  input  logic [NUM_SRC-1:0] src_rdy_i,
  output logic [SEL_W-1:0]   req_o,
  output logic [SEL_W-1:0]   cur_o,
  output logic               pend_o,
  output logic               mux_clk_o
);
  logic [SEL_W-1:0]   req_q, cur_q;
  logic               pend_q;
  logic [NUM_SRC-1:0] sel_oh;
  logic               old_low, new_low;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_sel
    assign sel_oh[g] = (cur_q == SEL_W'(g));
  end
  assign mux_clk_o = |(src_clk_i & sel_oh);

  assign old_low = !src_clk_i[cur_q];
  assign new_low = !src_clk_i[req_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      cur_q  <= '0;
      pend_q <= 1'b0;
    end else if (!pend_q) begin
      if (wr_i) begin
        req_q  <= wr_sel_i;
        pend_q <= wr_go_i;
      end
    end else if (!src_rdy_i[req_q]) begin
      pend_q <= 1'b0;                 // refused
    end else if (old_low && new_low) begin
      cur_q  <= req_q;
      pend_q <= 1'b0;
    end
  end

  assign req_o  = req_q;
  assign cur_o  = cur_q;
  assign pend_o = pend_q;

  // R4
  glitch_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q != $past(cur_q)) |-> (!$past(src_clk_i[cur_q]) && !$past(src_clk_i[req_q])));
  // R3
  change_on_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q != $past(cur_q)) |-> ($fell(pend_q) && cur_q == $past(req_q)));
  // R5
  reject_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(pend_q) && !$past(src_rdy_i[req_q])) |-> $stable(cur_q));
  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pend_q) |-> $stable(req_q));
endmodule

// File: rtl/sclk_slew_div.sv
module sclk_slew_div #(
  parameter int unsigned DIV_W  = 4,
  parameter int unsigned STEP_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              up_en_i,
  input  logic              dn_en_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic [DIV_W-1:0]  tgt_i,
  output logic              up_en_o,
  output logic              dn_en_o,
  output logic [STEP_W-1:0] step_o,
  output logic [DIV_W-1:0]  tgt_o,
  output logic [DIV_W-1:0]  act_o,
  output logic              busy_o
);
  logic [DIV_W-1:0]  tgt_q, act_q;
  logic [STEP_W-1:0] step_q, cnt_q;
  logic              up_q, dn_q;
  logic              going_up, slew_on;

  assign busy_o   = (tgt_q != act_q);
  assign going_up = (tgt_q < act_q);  // smaller division, higher frequency
  assign slew_on  = busy_o && (going_up ? up_q : dn_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q  <= '0;
      act_q  <= '0;
      step_q <= '0;
      cnt_q  <= '0;
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
    end else if (wr_i && !busy_o) begin
      tgt_q  <= tgt_i;
      step_q <= step_i;
      up_q   <= up_en_i;
      dn_q   <= dn_en_i;
      cnt_q  <= '0;
    end else if (busy_o) begin
      if (!slew_on) begin
        act_q <= tgt_q;
        cnt_q <= '0;
      end else if (cnt_q == step_q) begin
        act_q <= going_up ? act_q - DIV_W'(1) : act_q + DIV_W'(1);
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + STEP_W'(1);
      end
    end
  end

  assign up_en_o = up_q;
  assign dn_en_o = dn_q;
  assign step_o  = step_q;
  assign tgt_o   = tgt_q;
  assign act_o   = act_q;

  // R10
  one_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(slew_on) && !$stable(act_q)) |->
      ((act_q == $past(act_q) + DIV_W'(1)) || (act_q + DIV_W'(1) == $past(act_q))));
  // R12
  busy_cfg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_o) |-> ($stable(tgt_q) && $stable(step_q)));
  // R8
  settle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> $past(busy_o));
endmodule

// File: rtl/sclk_switch.sv
module sclk_switch
  import sclk_pkg::*;
#(
  parameter int unsigned NUM_SRC = SRC_MAX
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               addr_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   rdata_o,
  input  logic [NUM_SRC-1:0] src_clk_i,
  input  logic [NUM_SRC-1:0] src_rdy_i,
  output logic               mux_clk_o,
  output logic [DIV_FLD_W-1:0] div_act_o
);
  localparam int unsigned SEL_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic              wr_osc, wr_slew;
  logic [SEL_W-1:0]  req_sel, cur_sel;
  logic              pend;
  logic              up_en, dn_en, busy;
  logic [STEP_FLD_W-1:0] step;
  logic [DIV_FLD_W-1:0]  tgt;
  logic              unused_wdata;

  assign wr_osc  = wr_en_i && (addr_i == ADDR_OSC);
  assign wr_slew = wr_en_i && (addr_i == ADDR_SLEW);
  assign unused_wdata = ^{wdata_i[31:24], wdata_i[19:11], wdata_i[7:3]};

  sclk_src_switch #(.NUM_SRC(NUM_SRC), .SEL_W(SEL_W)) u_sw (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_osc),
    .wr_sel_i  (wdata_i[REQ_LSB +: SEL_W]),
    .wr_go_i   (wdata_i[GO_BIT]),
    .src_clk_i (src_clk_i),
    .src_rdy_i (src_rdy_i),
    .req_o     (req_sel),
    .cur_o     (cur_sel),
    .pend_o    (pend),
    .mux_clk_o (mux_clk_o)
  );

  sclk_slew_div #(.DIV_W(DIV_FLD_W), .STEP_W(STEP_FLD_W)) u_slew (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_slew),
    .up_en_i (wdata_i[UP_BIT]),
    .dn_en_i (wdata_i[DN_BIT]),
    .step_i  (wdata_i[STEP_LSB +: STEP_FLD_W]),
    .tgt_i   (wdata_i[DIV_LSB +: DIV_FLD_W]),
    .up_en_o (up_en),
    .dn_en_o (dn_en),
    .step_o  (step),
    .tgt_o   (tgt),
    .act_o   (div_act_o),
    .busy_o  (busy)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_OSC) begin
      rdata_o[GO_BIT]             = pend;
      rdata_o[REQ_LSB +: SEL_W]   = req_sel;
      rdata_o[CUR_LSB +: SEL_W]   = cur_sel;
    end else begin
      rdata_o[BUSY_BIT]                = busy;
      rdata_o[DN_BIT]                  = dn_en;
      rdata_o[UP_BIT]                  = up_en;
      rdata_o[STEP_LSB +: STEP_FLD_W]  = step;
      rdata_o[DIV_LSB +: DIV_FLD_W]    = tgt;
    end
  end
endmodule

// File: tb/sclk_switch_bench.sv
`timescale 1ns/1ps
module sclk_switch_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic        addr_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [7:0]  src_clk_i;
  logic [7:0]  src_rdy_i = 8'hFF;
  logic        mux_clk_o;
  logic [3:0]  div_act_o;

  logic [7:0]  src_gen = '0;
  logic [7:0]  force_hi = '0;
  int          src_cnt [8];
  int          n_chk = 0, n_err = 0;
  bit          done = 0;

  assign src_clk_i = src_gen | force_hi;

  always #4 clk_i = ~clk_i;

  sclk_switch u_sclk_switch (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .src_clk_i, .src_rdy_i, .mux_clk_o, .div_act_o
  );

  // source k has period 2*(k+1) cycles
  initial for (int k = 0; k < 8; k++) src_cnt[k] = 0;
  always @(posedge clk_i) begin
    for (int k = 0; k < 8; k++) begin
      if (src_cnt[k] == k) begin
        src_cnt[k] <= 0;
        src_gen[k] <= ~src_gen[k];
      end else src_cnt[k] <= src_cnt[k] + 1;
    end
  end

  // up, dn, step, from, to, expected busy cycles
  localparam logic [20:0] VEC [7] = '{
    {1'b0, 1'b0, 3'd0, 4'd3,  4'd7,  8'd1},
    {1'b0, 1'b1, 3'd2, 4'd2,  4'd6,  8'd12},
    {1'b1, 1'b0, 3'd1, 4'd9,  4'd4,  8'd10},
    {1'b1, 1'b0, 3'd0, 4'd0,  4'd5,  8'd1},
    {1'b0, 1'b1, 3'd7, 4'd15, 4'd14, 8'd1},
    {1'b1, 1'b1, 3'd3, 4'd0,  4'd15, 8'd60},
    {1'b1, 1'b1, 3'd0, 4'd8,  4'd7,  8'd1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  function automatic logic [31:0] slew_word(bit up, bit dn, int step, int div);
    return (32'(div) << 20) | (32'(step) << 8) | (32'(up) << 2) | (32'(dn) << 1);
  endfunction

  task automatic wait_idle_slew();
    addr_i = 1'b1; #1;
    for (int i = 0; i < 300 && rdata_o[0]; i++) begin @(negedge clk_i); #1; end
  endtask

  // poll go bit; returns cycles and source levels sampled before the finishing edge
  task automatic wait_switch(output int cyc, output logic [7:0] prev);
    logic [7:0] last;
    addr_i = 1'b0; #1;
    cyc = 0; last = src_clk_i; prev = last;
    while (rdata_o[0] && cyc < 100) begin
      last = src_clk_i;
      @(negedge clk_i); #1;
      prev = last;
      cyc++;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    int cyc;
    logic [7:0] prev;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    addr_i = 1'b0; #1;
    chk(rdata_o == 32'd0, "R1 osc reg", int'(rdata_o), 0);
    addr_i = 1'b1; #1;
    chk(rdata_o == 32'd0, "R1 slew reg", int'(rdata_o), 0);
    chk(div_act_o == 4'd0, "R1 div", int'(div_act_o), 0);

    // slew table: R9 R10 R11 R8
    foreach (VEC[i]) begin
      int n;
      logic [20:0] v;
      v = VEC[i];
      wr(1'b1, slew_word(0, 0, 0, int'(v[15:12])));
      wait_idle_slew();
      chk(div_act_o == v[15:12], "R9 preset", int'(div_act_o), int'(v[15:12]));
      wr(1'b1, slew_word(v[20], v[19], int'(v[18:16]), int'(v[11:8])));
      addr_i = 1'b1; #1;
      n = 0;
      while (rdata_o[0] && n < 500) begin n++; @(negedge clk_i); #1; end
      chk(n == int'(v[7:0]), "R10 busy cycles", n, int'(v[7:0]));
      chk(div_act_o == v[11:8], "R8 settled", int'(div_act_o), int'(v[11:8]));
    end

    // R7 readback and R12 busy write ignored
    wr(1'b1, slew_word(0, 0, 0, 0));
    wait_idle_slew();
    wr(1'b1, slew_word(0, 1, 7, 15));
    addr_i = 1'b1; #1;
    chk(rdata_o == 32'h00F0_0703, "R7 readback", int'(rdata_o), 32'h00F0_0703);
    wr(1'b1, slew_word(1, 0, 0, 2));
    addr_i = 1'b1; #1;
    chk(rdata_o[23:20] == 4'd15, "R12 target kept", int'(rdata_o[23:20]), 15);
    chk(rdata_o[2:1] == 2'b01, "R12 enables kept", int'(rdata_o[2:1]), 1);
    wait_idle_slew();

    // R3 R4 accepted switch to 3
    wr(1'b0, 32'h0000_0301);
    wait_switch(cyc, prev);
    chk(rdata_o[14:12] == 3'd3, "R3 cur", int'(rdata_o[14:12]), 3);
    chk(rdata_o[10:8] == 3'd3, "R2 req field", int'(rdata_o[10:8]), 3);
    chk(prev[0] == 1'b0 && prev[3] == 1'b0, "R4 both low", int'(prev), 0);
    for (int j = 0; j < 8; j++) begin
      @(negedge clk_i);
      chk(mux_clk_o == src_clk_i[3], "R3 follows", int'(mux_clk_o), int'(src_clk_i[3]));
    end

    // R5 refused at start
    src_rdy_i[5] = 1'b0;
    wr(1'b0, 32'h0000_0501);
    wait_switch(cyc, prev);
    chk(rdata_o[0] == 1'b0, "R5 go cleared", int'(rdata_o[0]), 0);
    chk(rdata_o[14:12] == 3'd3, "R5 cur kept", int'(rdata_o[14:12]), 3);
    src_rdy_i[5] = 1'b1;

    // R6 write ignored while pending, then completes
    force_hi[6] = 1'b1;
    wr(1'b0, 32'h0000_0601);
    repeat (4) @(negedge clk_i);
    wr(1'b0, 32'h0000_0201);
    addr_i = 1'b0; #1;
    chk(rdata_o[10:8] == 3'd6, "R6 req kept", int'(rdata_o[10:8]), 6);
    chk(rdata_o[0] == 1'b1, "R6 still pending", int'(rdata_o[0]), 1);
    force_hi[6] = 1'b0;
    wait_switch(cyc, prev);
    chk(rdata_o[14:12] == 3'd6, "R3 cur after wait", int'(rdata_o[14:12]), 6);
    chk(prev[3] == 1'b0 && prev[6] == 1'b0, "R4 both low", int'(prev), 0);

    // R5 ready drops while waiting
    force_hi[1] = 1'b1;
    wr(1'b0, 32'h0000_0101);
    repeat (3) @(negedge clk_i);
    addr_i = 1'b0; #1;
    chk(rdata_o[0] == 1'b1, "R5 pending", int'(rdata_o[0]), 1);
    src_rdy_i[1] = 1'b0;
    wait_switch(cyc, prev);
    chk(rdata_o[0] == 1'b0, "R5 go cleared late", int'(rdata_o[0]), 0);
    chk(rdata_o[14:12] == 3'd6, "R5 cur kept late", int'(rdata_o[14:12]), 6);
    force_hi[1] = 1'b0;
    src_rdy_i[1] = 1'b1;

    // R2 write without go only updates request
    wr(1'b0, 32'h0000_0400);
    addr_i = 1'b0; #1;
    chk(rdata_o == 32'h0000_6400, "R2 no go", int'(rdata_o), 32'h6400);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule